// File: doc/BRIEF.md
# Stepped Waveform Code Generator

This block drives the 8-bit input of a parallel digital-to-analogue converter with a stream of codes. One code step equals the converter's full-scale reference divided by 256. In run mode it sweeps one of four shapes: a rising ramp that wraps, a triangle that turns around at both ends, a square wave with an adjustable dwell, or a sine read from a built-in 64-point table. A single-cycle step strobe paces the sweep, so the output rate is set by how often the surrounding logic raises it.

Outside run mode the same code register holds a static level. An operator nudges it with separate up and down requests that stop at the ends of the range. When run mode is dropped, the code freezes where it was, and the manual requests continue from that value. All shapes share the one register, so switching mode mid-sweep continues from the present code.

Top module: `wave_pattern_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the code to 0, the triangle direction to rising, the square level to low, the sine phase to 0 and the square dwell count to 0.
- R2: With `run` high and `wave_sel` = 0 (ramp), each accepted step raises the code by one, and 255 is followed by 0.
- R3: With `wave_sel` = 1 (triangle), each accepted step moves the code one step in the present direction. At 255 the direction turns to falling and at 0 it turns to rising, so from reset the codes are 1..255, 254..0, 1, ... and the code never jumps between 0 and 255.
- R4: With `wave_sel` = 2 (square), the code is only ever 0 or 255. From reset the k-th accepted step gives 255 when floor(k/(`dwell`+1)) is odd and 0 otherwise, so each level lasts `dwell`+1 steps.
- R5: With `wave_sel` = 3 (sine), the k-th accepted step after reset (k counted from 0) outputs 128 + round(127·sin(2π·(k mod 64)/64)), from a 6-bit phase that advances once per step.
- R6: In run mode the code changes only on a cycle where `step_en` is high, and it changes by exactly one pattern step per such cycle. The new code appears at the clock edge that samples the strobe.
- R7: With `run` low, each cycle with `inc_req` high and `dec_req` low raises the code by one, up to 255, where it stays.
- R8: With `run` low, each cycle with `dec_req` high and `inc_req` low lowers the code by one, down to 0, where it stays.
- R9: The code holds when both requests are high together or both are low outside run mode. In run mode the requests have no effect.
- R10: Dropping `run` freezes the code even while `step_en` keeps pulsing, and the manual requests then act from the frozen value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | High: sweep the selected waveform; low: manual hold |
| wave_sel | input | 2 | 0 ramp, 1 triangle, 2 square, 3 sine |
| step_en | input | 1 | Step strobe that paces the sweep |
| inc_req | input | 1 | Manual increase request (used when run is low) |
| dec_req | input | 1 | Manual decrease request (used when run is low) |
| dwell | input | HOLD_W | Square dwell count; each level lasts dwell+1 steps |
| dac_code | output | 8 | Code for the converter input |

## Verification
The bench goes after the turning points. An off-by-one at the triangle apex would repeat 255 or skip to 253, and a wrapping triangle would jump from 0 to 255. It sweeps several dwell values, including zero, because a miscounted dwell produces square levels of the wrong length. It walks every sine phase twice against the formula, so a wrong fold of the quarter table shows up as a bad value near 90, 180 or 270 degrees. It also holds the manual requests at both ends well past saturation, drops the strobe at intervals, and toggles run mid-sweep. A design that wrapped, stepped without a strobe, or kept sweeping after run fell would give a wrong code at a known cycle.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

    localparam int CODE_W  = 8;
    localparam int PHASE_W = 6;
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_MIN = '0;

    typedef enum logic [1:0] {
        WAVE_RAMP   = 2'd0,
        WAVE_TRI    = 2'd1,
        WAVE_SQUARE = 2'd2,
        WAVE_SINE   = 2'd3
    } wave_e;

    typedef struct packed {
        logic [CODE_W-1:0]  code;
        logic               falling;
        logic [PHASE_W-1:0] phase;
    } gen_state_t;

endpackage

// File: rtl/wg_sine_rom.sv
module wg_sine_rom
    import wavegen_pkg::*;
(
    input  logic [PHASE_W-1:0] idx,
    output logic [CODE_W-1:0]  val
);
    logic [4:0] lane;
    logic [4:0] fold;
    logic [6:0] mag;

    always_comb begin
        lane = idx[4:0];
        fold = (lane <= 5'd16) ? lane : 5'(6'd32 - {1'b0, lane});
    end

    // quarter period: round(127 * sin(2*pi*n/64)) for n = 0..16
    always_comb begin
        case (fold)
            5'd0:    mag = 7'd0;
            5'd1:    mag = 7'd12;
            5'd2:    mag = 7'd25;
            5'd3:    mag = 7'd37;
            5'd4:    mag = 7'd49;
            5'd5:    mag = 7'd60;
            5'd6:    mag = 7'd71;
            5'd7:    mag = 7'd81;
            5'd8:    mag = 7'd90;
            5'd9:    mag = 7'd98;
            5'd10:   mag = 7'd106;
            5'd11:   mag = 7'd112;
            5'd12:   mag = 7'd117;
            5'd13:   mag = 7'd122;
            5'd14:   mag = 7'd125;
            5'd15:   mag = 7'd126;
            default: mag = 7'd127;
        endcase
    end

    always_comb begin
        val = idx[5] ? (8'd128 - {1'b0, mag}) : (8'd128 + {1'b0, mag});
    end

    // R5: the positive half never falls under mid-scale, the negative half never exceeds it
    always_comb begin
        a_r5_half_sign: assert (idx[5] ? (val <= 8'd128) : (val >= 8'd128));
    end

endmodule

// File: rtl/wg_square_timer.sv
module wg_square_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [HOLD_W-1:0] dwell,
    output logic              level_d
);
    typedef struct packed {
        logic [HOLD_W-1:0] cnt;
        logic              level;
    } sq_state_t;

    sq_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            if (st_q.cnt >= dwell) begin
                st_d.cnt   = '0;
                st_d.level = ~st_q.level;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        level_d = st_d.level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: the level only moves on an accepted square step
    a_r4_level_needs_step: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(st_q.level));
    // R4: a level change always restarts the dwell count
    a_r4_count_restarts: assert property (@(posedge clk) disable iff (rst)
        (advance && (st_q.level != level_d)) |=> (st_q.cnt == '0));

endmodule

// File: rtl/wg_code_next.sv
module wg_code_next
    import wavegen_pkg::*;
(
    input  wave_e              sel,
    input  logic [CODE_W-1:0]  code_q,
    input  logic               falling_q,
    input  logic               sq_level,
    input  logic [CODE_W-1:0]  sine_val,
    output logic [CODE_W-1:0]  code_nx,
    output logic               falling_nx
);
    always_comb begin
        code_nx    = code_q;
        falling_nx = falling_q;
        unique case (sel)
            WAVE_RAMP: begin
                code_nx = code_q + 1'b1;
            end
            WAVE_TRI: begin
                if (!falling_q) begin
                    if (code_q == CODE_MAX) begin
                        falling_nx = 1'b1;
                        code_nx    = code_q - 1'b1;
                    end else begin
                        code_nx = code_q + 1'b1;
                    end
                end else begin
                    if (code_q == CODE_MIN) begin
                        falling_nx = 1'b0;
                        code_nx    = code_q + 1'b1;
                    end else begin
                        code_nx = code_q - 1'b1;
                    end
                end
            end
            WAVE_SQUARE: begin
                code_nx = sq_level ? CODE_MAX : CODE_MIN;
            end
            WAVE_SINE: begin
                code_nx = sine_val;
            end
            default: begin
                code_nx = code_q;
            end
        endcase
    end

    // R3: a triangle step never jumps between the ends of the range
    always_comb begin
        a_r3_no_wrap: assert (sel != WAVE_TRI ||
            !((code_q == CODE_MAX && code_nx == CODE_MIN) ||
              (code_q == CODE_MIN && code_nx == CODE_MAX)));
    end

endmodule

// File: rtl/wave_pattern_gen.sv
module wave_pattern_gen
    import wavegen_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [1:0]        wave_sel,
    input  logic              step_en,
    input  logic              inc_req,
    input  logic              dec_req,
    input  logic [HOLD_W-1:0] dwell,
    output logic [7:0]        dac_code
);
    gen_state_t st_q, st_d;

    wave_e              sel;
    logic               stepping;
    logic               sq_level_d;
    logic [CODE_W-1:0]  sine_val;
    logic [CODE_W-1:0]  code_nx;
    logic               falling_nx;

    assign sel      = wave_e'(wave_sel);
    assign stepping = run && step_en;

    wg_sine_rom u_rom (
        .idx (st_q.phase),
        .val (sine_val)
    );

    wg_square_timer #(.HOLD_W(HOLD_W)) u_sq (
        .clk     (clk),
        .rst     (rst),
        .advance (stepping && (sel == WAVE_SQUARE)),
        .dwell   (dwell),
        .level_d (sq_level_d)
    );

    wg_code_next u_nx (
        .sel        (sel),
        .code_q     (st_q.code),
        .falling_q  (st_q.falling),
        .sq_level   (sq_level_d),
        .sine_val   (sine_val),
        .code_nx    (code_nx),
        .falling_nx (falling_nx)
    );

    always_comb begin
        st_d = st_q;
        if (run) begin
            if (step_en) begin
                st_d.code    = code_nx;
                st_d.falling = falling_nx;
                if (sel == WAVE_SINE) begin
                    st_d.phase = st_q.phase + 1'b1;
                end
            end
        end else if (inc_req && !dec_req) begin
            if (st_q.code != CODE_MAX) begin
                st_d.code = st_q.code + 1'b1;
            end
        end else if (dec_req && !inc_req) begin
            if (st_q.code != CODE_MIN) begin
                st_d.code = st_q.code - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_code = st_q.code;

    // R2: ramp steps by one and wraps
    a_r2_ramp_step: assert property (@(posedge clk) disable iff (rst)
        (stepping && sel == WAVE_RAMP) |=> (dac_code == 8'($past(dac_code) + 1)));
    // R4: square output sits at an end of the range
    a_r4_square_ends: assert property (@(posedge clk) disable iff (rst)
        (stepping && sel == WAVE_SQUARE) |=> (dac_code == CODE_MAX || dac_code == CODE_MIN));
    // R6: no strobe in run mode, no change
    a_r6_hold_without_step: assert property (@(posedge clk) disable iff (rst)
        (run && !step_en) |=> $stable(dac_code));
    // R7: manual increase stops at the top
    a_r7_top_saturates: assert property (@(posedge clk) disable iff (rst)
        (!run && inc_req && !dec_req && dac_code == CODE_MAX) |=> (dac_code == CODE_MAX));
    // R8: manual decrease stops at the bottom
    a_r8_bottom_saturates: assert property (@(posedge clk) disable iff (rst)
        (!run && dec_req && !inc_req && dac_code == CODE_MIN) |=> (dac_code == CODE_MIN));
    // R9 / R10: no net request outside run mode keeps the code frozen
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        (!run && (inc_req == dec_req)) |=> $stable(dac_code));

endmodule

// File: tb/wave_pattern_gen_tb_top.sv
module wave_pattern_gen_tb_top;

    localparam int HOLD_W = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              run;
    logic [1:0]        wave_sel;
    logic              step_en;
    logic              inc_req;
    logic              dec_req;
    logic [HOLD_W-1:0] dwell;
    logic [7:0]        dac_code;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wave_pattern_gen #(.HOLD_W(HOLD_W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .wave_sel (wave_sel),
        .step_en  (step_en),
        .inc_req  (inc_req),
        .dec_req  (dec_req),
        .dwell    (dwell),
        .dac_code (dac_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // inputs are set at a falling edge; one rising edge; sample at the next falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; run = 1'b0; wave_sel = 2'd0; step_en = 1'b0;
        inc_req = 1'b0; dec_req = 1'b0;
        tick();
        tick();
        rst = 1'b0;
    endtask

    function automatic int sine_ref(input int k);
        real v;
        int  r;
        v = 127.0 * $sin(2.0 * 3.14159265358979 * real'(k % 64) / 64.0);
        r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
        return 128 + r;
    endfunction

    initial begin
        dwell = '0;
        @(negedge clk);
        do_reset();
        chk("R1 reset code", int'(dac_code), 0);

        // R7: manual increase, held well past the top
        for (int k = 1; k <= 300; k++) begin
            inc_req = 1'b1;
            tick();
            chk("R7 manual up", int'(dac_code), (k < 255) ? k : 255);
        end
        inc_req = 1'b0;
        // R8: manual decrease, held well past the bottom
        for (int k = 1; k <= 300; k++) begin
            dec_req = 1'b1;
            tick();
            chk("R8 manual down", int'(dac_code), (255 - k > 0) ? 255 - k : 0);
        end
        dec_req = 1'b0;

        // R2 + R6 + R9: ramp with a gapped strobe and requests that must be ignored
        do_reset();
        begin
            int s = 0;
            wave_sel = 2'd0; run = 1'b1; inc_req = 1'b1;
            for (int k = 0; k < 700; k++) begin
                step_en = (k % 3) != 0;
                if (step_en) s++;
                tick();
                chk("R2 R6 R9 ramp", int'(dac_code), s % 256);
            end
            inc_req = 1'b0; step_en = 1'b0;
        end

        // R1 + R3: triangle from reset
        do_reset();
        wave_sel = 2'd1; run = 1'b1; step_en = 1'b1;
        for (int k = 1; k <= 1100; k++) begin
            int p;
            p = k % 510;
            tick();
            chk("R3 triangle", int'(dac_code), (p <= 255) ? p : 510 - p);
        end

        // R10: freeze on leaving run, manual from the frozen value
        do_reset();
        wave_sel = 2'd1; run = 1'b1; step_en = 1'b1;
        for (int k = 0; k < 300; k++) tick();
        chk("R3 apex turn", int'(dac_code), 210);
        run = 1'b0;
        for (int k = 0; k < 5; k++) begin
            tick();
            chk("R10 frozen", int'(dac_code), 210);
        end
        inc_req = 1'b1;
        tick();
        chk("R10 manual from frozen", int'(dac_code), 211);
        inc_req = 1'b0; dec_req = 1'b1;
        tick();
        tick();
        chk("R10 manual down from frozen", int'(dac_code), 209);
        inc_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R9 both requests", int'(dac_code), 209);
        end
        inc_req = 1'b0; dec_req = 1'b0;
        step_en = 1'b0;

        // R4: square for several dwell values
        for (int n = 0; n < 4; n++) begin
            int dv;
            dv = (n == 3) ? 7 : n;
            do_reset();
            dwell = HOLD_W'(dv);
            wave_sel = 2'd2; run = 1'b1; step_en = 1'b1;
            for (int k = 1; k <= 40; k++) begin
                tick();
                chk("R4 square", int'(dac_code), (((k / (dv + 1)) % 2) == 1) ? 255 : 0);
            end
        end

        // R5: sine, two full periods
        do_reset();
        wave_sel = 2'd3; run = 1'b1; step_en = 1'b1;
        for (int k = 0; k < 128; k++) begin
            tick();
            chk("R5 sine", int'(dac_code), sine_ref(k));
        end
        step_en = 1'b0;
        tick();
        chk("R6 sine hold", int'(dac_code), sine_ref(127));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule